// File: doc/BRIEF.md
# Shoot-Through Carrier PWM Cell

This block drives the four switches of one H-bridge cell in a cascaded multilevel inverter whose cells are fed through impedance-source boost networks. A digital up/down counter forms a triangular carrier for this cell alone. The cell's own signed reference is compared with the carrier to choose between the active and zero states of the bridge. Two symmetric threshold lines, at plus and minus an unsigned threshold, mark the regions near the carrier extremes. Whenever the carrier lies outside the band between them, the bridge is driven into the shoot-through state. In that state all four switches conduct and the network's inductors charge, which raises the cell's output voltage.

The threshold sets the boost. With the carrier peak called P and the threshold T, the fraction of each carrier quarter spent in shoot-through is (P − T)/P. A threshold at or above the peak gives no boost. A phase offset, loaded at reset, shifts this cell's carrier so that the cells of a phase can be interleaved. Reference and threshold are sampled only at the carrier's positive peak, so a carrier period never mixes two settings. Leg gates are complementary with no dead time inserted; dead time is left to the gate driver.

Top module: `stpwm_cell`

## Requirements
- R1: While reset is held, and in the first cycle after release with offset 0, the latched reference is 0 and the latched threshold equals PEAK. No shoot-through is flagged and gate_o reads 4'b1010 (both lower switches on).
- R2: The carrier moves by exactly one count each clock, turns at +PEAK and −PEAK, and repeats every 4·PEAK clocks, so pk_o pulses once every 4·PEAK cycles.
- R3: pk_o is high in exactly those cycles where the carrier equals +PEAK.
- R4: Carrier position n (0 ≤ n < 4·PEAK) has value n for n ≤ PEAK, 2·PEAK − n for n ≤ 3·PEAK, and n − 4·PEAK above that. Reset loads position ofs_in mod 4·PEAK, and counting rises from there.
- R5: Outside shoot-through, gate_o[0] (leg A upper) is high exactly when the latched reference is greater than the carrier, and gate_o[1] (leg A lower) is its complement.
- R6: Outside shoot-through, gate_o[2] (leg B upper) is high exactly when the negated latched reference is greater than the carrier, and gate_o[3] (leg B lower) is its complement.
- R7: When the carrier is greater than the latched threshold, or less than its negation, st_o is high and gate_o is 4'b1111, overriding R5 and R6.
- R8: A latched threshold at or above PEAK never produces shoot-through.
- R9: ref_in and thr_in are captured at the clock edge that ends a cycle with pk_o high, and take effect from the next cycle. Changes at any other time have no effect on the outputs until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | DW (signed) | Modulating reference, meaningful range −PEAK..+PEAK |
| thr_in | input | DW | Shoot-through threshold magnitude |
| ofs_in | input | clog2(4·PEAK) | Carrier start position, loaded during reset |
| gate_o | output | 4 | {B lower, B upper, A lower, A upper} gate commands |
| st_o | output | 1 | Shoot-through active |
| pk_o | output | 1 | Carrier at positive peak |

## Verification
A cycle-accurate reference model in the bench predicts all outputs each cycle. The reference is swept through zero, positive, negative and out-of-range values. Zero tells apart the two zero states; positive and negative show which leg leads. Values beyond the peak check saturation behaviour. Thresholds below the peak, at the peak and at the top of the field show where shoot-through starts and that it stays off when no boost is set. The reference and threshold are changed in the middle of a carrier period to show that nothing changes before the next peak. Resets with several offsets, including one landing on the peak itself, confirm the start position and the peak-to-peak spacing.

// File: rtl/stpwm_pkg.sv
package stpwm_pkg;

  // Triangular carrier value at phase position ph for a peak of pk.
  function automatic int tri_of(int ph, int pk);
    if (ph <= pk)          return ph;
    else if (ph <= 3 * pk) return 2 * pk - ph;
    else                   return ph - 4 * pk;
  endfunction

  // Carrier outside the symmetric threshold band.
  function automatic logic st_hit(int car, int thr);
    return (car > thr) || (car < -thr);
  endfunction

  // Gate vector {b_lo, b_hi, a_lo, a_hi}.
  function automatic logic [3:0] leg_map(int car, int rf, logic st);
    logic a_hi;
    logic b_hi;
    a_hi = (rf > car);
    b_hi = (-rf > car);
    if (st) return 4'hF;
    return {~b_hi, b_hi, ~a_hi, a_hi};
  endfunction

endpackage

// File: rtl/stpwm_carrier.sv
module stpwm_carrier #(
  parameter int PEAK = 8,
  localparam int PH_N = 4 * PEAK,
  localparam int PH_W = $clog2(PH_N),
  localparam int CW   = $clog2(PEAK + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PH_W-1:0]      ofs,
  output logic signed [CW-1:0] car,
  output logic                 pk
);
  logic [PH_W-1:0] ph;
  logic            run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_W'(int'(ofs) % PH_N);
      run_q <= 1'b0;
    end else begin
      ph    <= (ph == PH_W'(PH_N - 1)) ? '0 : ph + 1'b1;
      run_q <= 1'b1;
    end
  end

  assign car = CW'(stpwm_pkg::tri_of(int'(ph), PEAK));
  assign pk  = (ph == PH_W'(PEAK));

  AST_CAR_STEP: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ((int'(car) - int'($past(car)) == 1) || (int'($past(car)) - int'(car) == 1))); // R2
  AST_CAR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(car) <= PEAK) && (int'(car) >= -PEAK)); // R2
  AST_PEAK_TURN: assert property (@(posedge clk) disable iff (rst)
    pk |=> (int'(car) == PEAK - 1)); // R3

endmodule

// File: rtl/stpwm_latch.sv
module stpwm_latch #(
  parameter int PEAK = 8,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pk,
  input  logic signed [DW-1:0] ref_in,
  input  logic [DW-1:0]        thr_in,
  output logic signed [DW-1:0] ref_q,
  output logic [DW-1:0]        thr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      thr_q <= DW'(PEAK);
    end else if (pk) begin
      ref_q <= ref_in;
      thr_q <= thr_in;
    end
  end

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !$past(pk) |-> ($stable(ref_q) && $stable(thr_q))); // R9

endmodule

// File: rtl/stpwm_cmp.sv
module stpwm_cmp #(
  parameter int PEAK = 8,
  parameter int DW   = 8,
  localparam int CW  = $clog2(PEAK + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [CW-1:0] car,
  input  logic signed [DW-1:0] ref_q,
  input  logic [DW-1:0]        thr_q,
  output logic [3:0]           gate,
  output logic                 st
);
  always_comb begin
    st   = stpwm_pkg::st_hit(int'(car), int'(thr_q));
    gate = stpwm_pkg::leg_map(int'(car), int'(ref_q), st);
  end

  AST_ST_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    st |-> (gate == 4'hF)); // R7
  AST_LEG_COMPL: assert property (@(posedge clk) disable iff (rst)
    !st |-> ((gate[0] != gate[1]) && (gate[2] != gate[3]))); // R5
  AST_NO_BOOST: assert property (@(posedge clk) disable iff (rst)
    (int'(thr_q) >= PEAK) |-> !st); // R8

endmodule

// File: rtl/stpwm_cell.sv
module stpwm_cell #(
  parameter int PEAK = 8,
  parameter int DW   = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic signed [DW-1:0]            ref_in,
  input  logic [DW-1:0]                   thr_in,
  input  logic [$clog2(4*PEAK)-1:0]       ofs_in,
  output logic [3:0]                      gate_o,
  output logic                            st_o,
  output logic                            pk_o
);
  localparam int CW = $clog2(PEAK + 1) + 1;

  logic signed [CW-1:0] car_w;
  logic                 pk_w;
  logic signed [DW-1:0] ref_q;
  logic [DW-1:0]        thr_q;
  logic                 st_w;
  logic [3:0]           gate_w;

  stpwm_carrier #(.PEAK(PEAK)) u_car (
    .clk(clk), .rst(rst), .ofs(ofs_in), .car(car_w), .pk(pk_w)
  );

  stpwm_latch #(.PEAK(PEAK), .DW(DW)) u_lat (
    .clk(clk), .rst(rst), .pk(pk_w), .ref_in(ref_in), .thr_in(thr_in),
    .ref_q(ref_q), .thr_q(thr_q)
  );

  stpwm_cmp #(.PEAK(PEAK), .DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .car(car_w), .ref_q(ref_q), .thr_q(thr_q),
    .gate(gate_w), .st(st_w)
  );

  assign gate_o = gate_w;
  assign st_o   = st_w;
  assign pk_o   = pk_w;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!st_o && (int'(thr_q) == PEAK) && (ref_q == '0))); // R1

endmodule

// File: tb/stpwm_cell_tb.sv
module stpwm_cell_tb;
  localparam int PEAK  = 8;
  localparam int DW    = 8;
  localparam int PH_W  = $clog2(4 * PEAK);
  localparam int TCLK  = 10;
  localparam int WDOG  = 20000;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [DW-1:0] ref_in = '0;
  logic [DW-1:0]        thr_in = DW'(PEAK);
  logic [PH_W-1:0]      ofs_in = '0;
  logic [3:0]           gate_o;
  logic                 st_o;
  logic                 pk_o;

  stpwm_cell #(.PEAK(PEAK), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .thr_in(thr_in), .ofs_in(ofs_in),
    .gate_o(gate_o), .st_o(st_o), .pk_o(pk_o)
  );

  always #(TCLK/2) clk = ~clk;

  typedef struct {
    logic [3:0] g;
    logic       st;
    logic       pk;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   last_pk = -1;
  bit   done = 1'b0;

  // bench model state
  int m_car, m_up, m_ref, m_thr;

  function automatic void model_reset(int ofs);
    m_car = 0; m_up = 1; m_ref = 0; m_thr = PEAK;
    for (int i = 0; i < ofs % (4 * PEAK); i++) model_adv();
  endfunction

  function automatic void model_adv();
    if (m_up == 1) begin
      if (m_car == PEAK) begin m_car = m_car - 1; m_up = 0; end
      else m_car = m_car + 1;
    end else begin
      if (m_car == -PEAK) begin m_car = m_car + 1; m_up = 1; end
      else m_car = m_car - 1;
    end
  endfunction

  task automatic do_reset(int ofs);
    @(negedge clk);
    rst = 1'b1;
    ofs_in = PH_W'(ofs);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    last_pk = -1;
    model_reset(ofs);
  endtask

  // Drive one cycle at the current negedge, push expectation, advance model.
  task automatic step(int rf, int th, string req);
    exp_t e;
    bit   a, b, s;
    ref_in = DW'(rf);
    thr_in = DW'(th);
    s = (m_car > m_thr) || (m_car < -m_thr);
    a = (m_ref > m_car);
    b = (-m_ref > m_car);
    e.st  = s;
    e.g   = s ? 4'b1111 : {~b, b, ~a, a};
    e.pk  = (m_car == PEAK);
    e.req = req;
    q.push_back(e);
    if (e.pk) begin m_ref = rf; m_thr = th; end
    model_adv();
    @(negedge clk);
  endtask

  task automatic run(int n, int rf, int th, string req);
    for (int i = 0; i < n; i++) step(rf, th, req);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (gate_o !== e.g) begin
          n_bad++;
          $display("FAIL %s gate: actual %b expected %b", e.req, gate_o, e.g);
        end
        if (st_o !== e.st) begin
          n_bad++;
          $display("FAIL %s st: actual %b expected %b", e.req, st_o, e.st);
        end
        if (pk_o !== e.pk) begin
          n_bad++;
          $display("FAIL R3 pk (%s): actual %b expected %b", e.req, pk_o, e.pk);
        end
        if (pk_o === 1'b1) begin
          if (last_pk >= 0) begin
            n_vec++;
            if (cyc - last_pk != 4 * PEAK) begin
              n_bad++;
              $display("FAIL R2 peak spacing: actual %0d expected %0d", cyc - last_pk, 4 * PEAK);
            end
          end
          last_pk = cyc;
        end
        cyc++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    // R1: reset state, first cycle after release
    step(0, PEAK, "R1");
    // R2/R4: plain carrier with zero reference
    run(70, 0, PEAK, "R2");
    // R5: positive reference
    run(70, 5, PEAK, "R5");
    // R6: negative reference
    run(70, -3, PEAK, "R6");
    // R5 R6: reference beyond peak in both directions
    run(40, 9, PEAK, "R5");
    run(40, -9, PEAK, "R6");
    // R7: boost thresholds below the peak
    run(70, 4, 6, "R7");
    run(70, -2, 3, "R7");
    run(40, 0, 0, "R7");
    // R8: thresholds at and above the peak
    run(70, 4, PEAK, "R8");
    run(70, 4, 255, "R8");
    // R9: changes in the middle of a period only land at the next peak
    for (int k = 0; k < 6; k++) begin
      run(5, 6 - 2 * k, 2 + k, "R9");
      run(7, -6 + k, 7 - k, "R9");
    end
    // R4: phase offsets, including one starting on the peak
    do_reset(5);
    run(40, 2, 5, "R4");
    do_reset(PEAK);
    run(40, -4, 6, "R4");
    do_reset(20);
    run(40, 3, 7, "R4");
    do_reset(4 * PEAK - 1);
    run(40, 1, PEAK, "R4");
    // R1: reset again with offset 0 after boosted operation
    run(20, 5, 2, "R7");
    do_reset(0);
    step(7, 2, "R1");
    run(40, 7, 2, "R7");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule